// File: doc/BRIEF.md
# Priority Arbiter with Starvation Aging

The block picks one winner per clock among `N_REQ` requesters. Each requester drives a request bit and its own programmed priority. The requester with the highest effective priority wins, and the result appears on a registered one-hot grant vector one cycle later. A requester that keeps losing to others slowly gains ground. Each loss while pending advances a private wait counter. Once that counter meets a runtime threshold, the requester competes at one priority step above its programmed value.

Each requester owns a small aging state machine with three states:

- `AGE_IDLE`: not waiting, counter at zero.
- `AGE_WAIT`: pending and counting losses, still below the threshold.
- `AGE_BOOST`: threshold reached, priority raised.

The machine moves between these states on four named transitions:

- **lose-count** moves `AGE_IDLE`/`AGE_WAIT` to `AGE_WAIT` when a loss leaves the count below the threshold.
- **lose-age** moves `AGE_IDLE`/`AGE_WAIT` to `AGE_BOOST` when a loss brings the count to the threshold.
- **hold** keeps `AGE_BOOST` while the requester keeps losing.
- **release** returns any state to `AGE_IDLE`. It fires when the requester wins, drops its request, or sees a threshold of zero.

The effective priorities are driven out so that a neighbour or a checker can observe them.

Top module: `prio_age_arbiter`

## Requirements
- R1: The grant is registered. The grant seen after a rising clock edge is computed from the request vector and effective priorities present at that edge. It is all zero when no request bit was set at that edge.
- R2: The grant is one-hot or zero. Bit i of `grant` means requester i, and at most one bit is set.
- R3: The granted requester has an effective priority no lower than that of any other requester that was requesting at the same edge.
- R4: When several requesters tie on effective priority, the lowest-index one wins.
- R5: A requester's wait counter advances by one at each edge where it is requesting and another requester wins. When the counter reaches a non-zero `threshold`, the effective priority becomes the programmed priority plus one.
- R6: While the counter is below the threshold, the effective priority equals the programmed priority.
- R7: The counter stops at the threshold and never wraps. A boosted requester that keeps losing stays boosted.
- R8: The boosted priority saturates at 2^PRIO_W-1. A programmed maximum stays at the maximum.
- R9: A requester's counter and boost clear at the edge where it wins, or at the edge where its request bit is low.
- R10: A `threshold` of zero disables aging. After an edge with zero threshold, every effective priority equals its programmed priority.
- R11: An active-low asynchronous reset clears the grant to zero and puts every requester in `AGE_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_REQ | Request bit per requester |
| prio | input | N_REQ*PRIO_W | Programmed priorities; requester i in bits [i*PRIO_W +: PRIO_W], larger wins |
| threshold | input | THR_W | Losses needed before a boost; zero disables aging |
| grant | output | N_REQ | Registered one-hot grant |
| eff_prio | output | N_REQ*PRIO_W | Effective priorities, same field layout as `prio` |

## Verification
The bench builds the block with four requesters, 3-bit priorities and a 16-bit threshold. With 3-bit priorities, the saturating boost at value 7 can be reached with a single loss. Four requesters allow ties, a hidden high-priority requester that is not requesting, and a mix of winners in one table walk. Small thresholds of 1, 2 and 3 reach every transition of the aging machine within a few cycles. These include the first loss going straight to `AGE_BOOST`, the hold while boosted, and the release on win, drop, zero threshold and reset.

// File: rtl/prio_age_pkg.sv
package prio_age_pkg;

    typedef enum logic [1:0] {
        AGE_IDLE  = 2'd0,
        AGE_WAIT  = 2'd1,
        AGE_BOOST = 2'd2
    } age_state_e;

endpackage

// File: rtl/age_tracker.sv
module age_tracker
    import prio_age_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int THR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              won_i,
    input  logic              other_won_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic [PRIO_W-1:0] eff_prio_o
);

    localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

    age_state_e       st_q, st_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    logic [THR_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AGE_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            AGE_IDLE, AGE_WAIT: begin
                if (!req_i || won_i || thr_i == '0) begin
                    st_d  = AGE_IDLE;                 // release
                    cnt_d = '0;
                end else if (other_won_i) begin
                    if (cnt_inc >= {1'b0, thr_i}) begin
                        st_d  = AGE_BOOST;            // lose-age
                        cnt_d = thr_i;
                    end else begin
                        st_d  = AGE_WAIT;             // lose-count
                        cnt_d = cnt_inc[THR_W-1:0];
                    end
                end
            end
            AGE_BOOST: begin
                if (!req_i || won_i || thr_i == '0) begin
                    st_d  = AGE_IDLE;                 // release
                    cnt_d = '0;
                end                                   // else hold
            end
            default: begin
                st_d  = AGE_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        if (st_q == AGE_BOOST && prio_i != PRIO_MAX)
            eff_prio_o = prio_i + 1'b1;
        else
            eff_prio_o = prio_i;
    end

endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int N_REQ  = 4,
    parameter int PRIO_W = 3
) (
    input  logic [N_REQ-1:0]        req_i,
    input  logic [N_REQ*PRIO_W-1:0] eff_i,
    output logic [N_REQ-1:0]        win_o
);

    logic [PRIO_W-1:0] best;
    logic              found;

    always_comb begin
        win_o = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req_i[i] && (!found || eff_i[i*PRIO_W +: PRIO_W] > best)) begin
                win_o    = '0;
                win_o[i] = 1'b1;
                best     = eff_i[i*PRIO_W +: PRIO_W];
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_age_arbiter.sv
module prio_age_arbiter #(
    parameter int N_REQ  = 4,
    parameter int PRIO_W = 3,
    parameter int THR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req,
    input  logic [N_REQ*PRIO_W-1:0] prio,
    input  logic [THR_W-1:0]        threshold,
    output logic [N_REQ-1:0]        grant,
    output logic [N_REQ*PRIO_W-1:0] eff_prio
);

    logic [N_REQ-1:0] win_d;
    logic [N_REQ-1:0] grant_q;

    prio_select #(.N_REQ(N_REQ), .PRIO_W(PRIO_W)) sel_i (
        .req_i (req),
        .eff_i (eff_prio),
        .win_o (win_d)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_age
        logic other_won;
        assign other_won = |(win_d & ~(N_REQ'(1) << g));

        age_tracker #(.PRIO_W(PRIO_W), .THR_W(THR_W)) trk_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req[g]),
            .won_i       (win_d[g]),
            .other_won_i (other_won),
            .prio_i      (prio[g*PRIO_W +: PRIO_W]),
            .thr_i       (threshold),
            .eff_prio_o  (eff_prio[g*PRIO_W +: PRIO_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= win_d;
    end

    assign grant = grant_q;

endmodule

// File: rtl/prio_age_arbiter_chk.sv
module prio_age_arbiter_chk #(
    parameter int N_REQ  = 4,
    parameter int PRIO_W = 3,
    parameter int THR_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_REQ-1:0]        req,
    input logic [N_REQ*PRIO_W-1:0] prio,
    input logic [THR_W-1:0]        threshold,
    input logic [N_REQ-1:0]        grant,
    input logic [N_REQ*PRIO_W-1:0] eff_prio
);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R1
    grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> (|grant));

    // R1
    grant_was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (|(grant & $past(req))));

    // R10
    thr_zero_no_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold == '0) |=> (eff_prio == prio));

    for (genvar i = 0; i < N_REQ; i++) begin : g_req
        // R6
        eff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, eff_prio[i*PRIO_W +: PRIO_W]} >= {1'b0, prio[i*PRIO_W +: PRIO_W]}) &&
            ({1'b0, eff_prio[i*PRIO_W +: PRIO_W]} <= {1'b0, prio[i*PRIO_W +: PRIO_W]} + 1'b1));

        // R9
        winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (eff_prio[i*PRIO_W +: PRIO_W] == prio[i*PRIO_W +: PRIO_W]));

        for (genvar j = 0; j < N_REQ; j++) begin : g_other
            // R3
            winner_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[i] && $past(req[j])) |->
                ($past(eff_prio[j*PRIO_W +: PRIO_W]) <= $past(eff_prio[i*PRIO_W +: PRIO_W])));
        end
    end

endmodule

bind prio_age_arbiter prio_age_arbiter_chk #(
    .N_REQ(N_REQ), .PRIO_W(PRIO_W), .THR_W(THR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .threshold(threshold),
    .grant(grant), .eff_prio(eff_prio)
);

// File: tb/prio_age_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_age_arbiter_tb_top;

    localparam int N_REQ  = 4;
    localparam int PRIO_W = 3;
    localparam int THR_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_REQ-1:0]        req = '0;
    logic [N_REQ*PRIO_W-1:0] prio = '0;
    logic [THR_W-1:0]        threshold = '0;
    logic [N_REQ-1:0]        grant;
    logic [N_REQ*PRIO_W-1:0] eff_prio;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prio_age_arbiter #(.N_REQ(N_REQ), .PRIO_W(PRIO_W), .THR_W(THR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .threshold(threshold),
        .grant(grant), .eff_prio(eff_prio)
    );

    // {req, p3, p2, p1, p0, expected grant}, aging disabled
    localparam logic [19:0] VEC [8] = '{
        {4'b0000, 3'd3, 3'd3, 3'd3, 3'd3, 4'b0000},
        {4'b0001, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0001},
        {4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 4'b0001},
        {4'b1111, 3'd5, 3'd1, 3'd1, 3'd1, 4'b1000},
        {4'b0110, 3'd0, 3'd4, 3'd4, 3'd7, 4'b0010},
        {4'b1100, 3'd6, 3'd7, 3'd0, 3'd0, 4'b0100},
        {4'b1010, 3'd7, 3'd0, 3'd7, 3'd0, 4'b0010},
        {4'b1000, 3'd1, 3'd6, 3'd6, 3'd6, 4'b1000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PRIO_W-1:0] eff_of(input int i);
        return eff_prio[i*PRIO_W +: PRIO_W];
    endfunction

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11 reset state
        req = 4'b1111;
        prio = {3'd5, 3'd5, 3'd5, 3'd5};
        threshold = 16'd1;
        repeat (3) step();
        check("R11 grant in reset", 32'(grant), 32'(0));
        check("R11 eff in reset", 32'(eff_prio), 32'(prio));
        req = '0;
        threshold = '0;
        rst_n = 1'b1;
        step();

        // table walk: R1 R2 R3 R4 R10
        for (int k = 0; k < 8; k++) begin
            req  = VEC[k][19:16];
            prio = VEC[k][15:4];
            step();
            check("R3 R4 table grant", 32'(grant), 32'(VEC[k][3:0]));
            check("R10 table eff", 32'(eff_prio), 32'(VEC[k][15:4]));
        end

        // R5 R6 R4: threshold 3, p0=1 p1=2
        req = '0; step();
        threshold = 16'd3;
        prio = {3'd0, 3'd0, 3'd2, 3'd1};
        req = 4'b0011;
        step();
        check("R5 grant e1", 32'(grant), 32'(4'b0010));
        check("R6 eff0 e1", 32'(eff_of(0)), 32'(1));
        step();
        check("R6 eff0 e2", 32'(eff_of(0)), 32'(1));
        step();
        check("R5 grant e3", 32'(grant), 32'(4'b0010));
        check("R5 eff0 boosted e3", 32'(eff_of(0)), 32'(2));
        step();
        check("R4 tie after boost", 32'(grant), 32'(4'b0001));
        check("R9 eff0 cleared on win", 32'(eff_of(0)), 32'(1));
        step();
        check("R3 grant e5", 32'(grant), 32'(4'b0010));

        // R8: threshold 1, both at max
        req = '0; step();
        threshold = 16'd1;
        prio = {3'd0, 3'd0, 3'd7, 3'd7};
        req = 4'b0011;
        step();
        check("R8 grant", 32'(grant), 32'(4'b0001));
        check("R8 eff1 saturated", 32'(eff_of(1)), 32'(7));
        step();
        check("R8 eff1 still max", 32'(eff_of(1)), 32'(7));

        // R7 R9 R10 R11: threshold 2, p0=5 p1=3
        req = '0; step();
        threshold = 16'd2;
        prio = {3'd0, 3'd0, 3'd3, 3'd5};
        req = 4'b0011;
        step();
        check("R6 eff1 below threshold", 32'(eff_of(1)), 32'(3));
        step();
        check("R5 eff1 boosted", 32'(eff_of(1)), 32'(4));
        for (int c = 0; c < 4; c++) begin
            step();
            check("R7 eff1 holds boost", 32'(eff_of(1)), 32'(4));
        end
        rst_n = 1'b0;
        #1;
        check("R11 grant mid reset", 32'(grant), 32'(0));
        check("R11 eff1 mid reset", 32'(eff_of(1)), 32'(3));
        step();
        rst_n = 1'b1;
        step();
        check("R1 grant after reset", 32'(grant), 32'(4'b0001));
        check("R6 eff1 after reset", 32'(eff_of(1)), 32'(3));
        step();
        check("R5 eff1 boost again", 32'(eff_of(1)), 32'(4));
        req = 4'b0001;
        step();
        check("R9 eff1 cleared on drop", 32'(eff_of(1)), 32'(3));
        req = 4'b0011;
        step();
        check("R9 eff1 count restarted", 32'(eff_of(1)), 32'(3));
        step();
        check("R5 eff1 boost third", 32'(eff_of(1)), 32'(4));
        threshold = '0;
        step();
        check("R10 zero threshold clears boost", 32'(eff_of(1)), 32'(3));
        step();
        check("R10 stays unboosted", 32'(eff_of(1)), 32'(3));
        req = '0;
        step();
        check("R1 idle grant", 32'(grant), 32'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule